// File: doc/BRIEF.md
# Remote Terminal Data-Word Buffer Address Manager

This block works out where each data word of a serial-bus remote-terminal message lives in the shared buffer memory. When the protocol logic announces a message, the block takes the direction (receive, transmit or broadcast), the subaddress, the storage-scheme bits of that subaddress's control word and the active area select. From these it finds the stored pointer word in the lookup table in memory and fetches it through a synchronous RAM port. It then hands out one word address per request. When the message closes, it writes the updated pointer back, but only if the message was valid.

Four storage schemes are supported. A single 32-word block serves transmit subaddresses. A receive subaddress can use a ping-pong pair of 32-word blocks, where the stored pointer names the most recent complete block. Any subaddress can use a private ring of 128 to 8192 words. One ring can also be shared by all receive subaddresses, with its size taken from a configuration input. For ring schemes, the block flags the word after which the ring pointer reaches half of the ring, and the word after which it wraps to the start.

Top module: `dword_bufmgr`

## Requirements
- R1: After reset `busy`, `addrValid`, `midFlag`, `wrapFlag`, `memRe` and `memWe` are all 0.
- R2: In the cycle after an accepted `msgStart` (one sampled while `busy` is 0), `memRe` is 1 and `memAddr` is the pointer location. For a subaddress scheme the location is table base + dirIdx*32 + subaddress, with table base 0x0140 for area A (`areaSel`=0) and 0x01C0 for area B, and dirIdx 0 for receive, 1 for transmit and 2 for broadcast. The direction codes on `dirIn` are 0 receive, 1 transmit, 2 and 3 broadcast.
- R3: When `sepBcast` is 0, a broadcast message uses the receive table entry (dirIdx 0). When `sepBcast` is 1, it uses dirIdx 2.
- R4: A transmit message with `ctrlMm`=000 uses the single-block scheme whatever the value of `ctrlGlobal`. Word k gets address {ptr[15:5], k[4:0]}, and no pointer is written back.
- R5: A receive or broadcast message with `ctrlGlobal`=0 and `ctrlMm`=000 is double-buffered. Word k is written to the block not named by the pointer, {ptr[15:6], ~ptr[5], k[4:0]}. A valid end writes back ptr with bit 5 inverted.
- R6: `ctrlMm` codes 001 to 111 select a private ring of 128, 256, 512, 1024, 2048, 4096 or 8192 words. The first word uses the stored pointer. Each later word uses the previous address plus one, kept within the size-aligned window (its low log2(size) bits wrap).
- R7: A receive or broadcast message with `ctrlGlobal`=1 uses the shared ring. Its pointer is at 0x0101 (area A) or 0x0105 (area B), and its size is given by `globalSize` with the same encoding as R6 (000 is taken as 128).
- R8: With an address of a ring scheme, `midFlag` is 1 when the pointer after that word sits at offset size/2, and `wrapFlag` is 1 when it sits at offset 0. Both flags are 0 for the block schemes.
- R9: When `msgEnd` is given with `msgOk`=1 for a ring or double-buffered scheme, the next cycle has `memWe`=1 at the pointer location with the updated pointer, which is the ring position after the last word. When `msgOk`=0, nothing is written, so the stored pointer and the ping-pong selection stay unchanged.
- R10: `addrValid` and `wordAddr` appear exactly one cycle after a `wordReq` accepted in the active phase. A `wordReq` given while idle produces no address.
- R11: `areaSel` selects which pointer set (area A or area B) is read and written, for both the subaddress tables and the shared ring pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msgStart | input | 1 | Message start strobe, taken when idle |
| dirIn | input | 2 | Direction: 0 receive, 1 transmit, 2/3 broadcast |
| subAddr | input | 5 | Subaddress of the message |
| ctrlMm | input | 3 | Storage-scheme code from the subaddress control word |
| ctrlGlobal | input | 1 | Shared-ring select from the control word (receive/broadcast) |
| areaSel | input | 1 | Active pointer area, 0 = A, 1 = B |
| sepBcast | input | 1 | Keep broadcast data apart from receive data |
| globalSize | input | 3 | Shared-ring size code |
| wordReq | input | 1 | Request the address of the next data word |
| msgEnd | input | 1 | Message end strobe |
| msgOk | input | 1 | Message passed validation, sampled with msgEnd |
| busy | output | 1 | A message is in progress |
| wordAddr | output | 16 | Data-word address |
| addrValid | output | 1 | wordAddr is valid this cycle |
| midFlag | output | 1 | Ring reached its half point after this word |
| wrapFlag | output | 1 | Ring wrapped after this word |
| memAddr | output | 16 | Pointer RAM address |
| memRe | output | 1 | Pointer RAM read enable |
| memWe | output | 1 | Pointer RAM write enable |
| memWdata | output | 16 | Pointer write-back value |
| memRdata | input | 16 | Pointer RAM read data, one cycle after memRe |

## Verification
The properties assume well-behaved protocol logic. `msgStart` comes only while `busy` is low, `wordReq` and `msgEnd` come only after the two-cycle pointer fetch, the two never share a cycle, and ring pointers sit inside a buffer aligned to its size. The stimulus follows this by waiting out the fetch before the first request, raising `msgEnd` only after the request train has ended, and preloading aligned pointers in the memory model. A single stray `wordReq` is sent while idle on purpose.

// File: rtl/bufmgr_pkg.sv
package bufmgr_pkg;

  typedef enum logic [1:0] {
    DIR_RX = 2'd0,
    DIR_TX = 2'd1,
    DIR_BC = 2'd2
  } dir_e;

  typedef enum logic [1:0] {
    SCH_SINGLE = 2'd0,
    SCH_DOUBLE = 2'd1,
    SCH_RING   = 2'd2
  } scheme_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic latchCtx;
    logic loadPtr;
    logic advance;
  } strobe_t;

  // Ring size code to log2(words): 001 -> 7 (128) ... 111 -> 13 (8192), 000 -> 7
  function automatic logic [3:0] ringLog2(input logic [2:0] code);
    ringLog2 = (code == 3'd0) ? 4'd7 : 4'd6 + {1'b0, code};
  endfunction

endpackage

// File: rtl/bufmgr_ctrl.sv
module bufmgr_ctrl
  import bufmgr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    msgStart,
  input  logic    wordReq,
  input  logic    msgEnd,
  input  logic    msgOk,
  input  scheme_e scheme,
  output strobe_t stb,
  output logic    memRe,
  output logic    memWe,
  output logic    busy
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_LOAD, ST_ACTIVE, ST_WRBACK
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (msgStart) stateNext = ST_FETCH;
      ST_FETCH:  stateNext = ST_LOAD;
      ST_LOAD:   stateNext = ST_ACTIVE;
      ST_ACTIVE: begin
        if (msgEnd) begin
          if (msgOk && scheme != SCH_SINGLE) stateNext = ST_WRBACK;
          else                               stateNext = ST_IDLE;
        end
      end
      ST_WRBACK: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    stb.latchCtx = (state == ST_IDLE) && msgStart;
    stb.loadPtr  = (state == ST_LOAD);
    stb.advance  = (state == ST_ACTIVE) && wordReq && !msgEnd;
    memRe        = (state == ST_FETCH);
    memWe        = (state == ST_WRBACK);
    busy         = (state != ST_IDLE);
  end

endmodule

// File: rtl/bufmgr_dpath.sv
module bufmgr_dpath
  import bufmgr_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          SA_W       = 5,
  parameter int          BLK_W      = 5,
  parameter logic [15:0] TBL_A_BASE = 16'h0140,
  parameter logic [15:0] TBL_B_BASE = 16'h01C0,
  parameter logic [15:0] RING_A_LOC = 16'h0101,
  parameter logic [15:0] RING_B_LOC = 16'h0105
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [1:0]        dirIn,
  input  logic [SA_W-1:0]   subAddr,
  input  logic [2:0]        ctrlMm,
  input  logic              ctrlGlobal,
  input  logic              areaSel,
  input  logic              sepBcast,
  input  logic [2:0]        globalSize,
  input  logic [ADDR_W-1:0] memRdata,
  output scheme_e           scheme,
  output logic [ADDR_W-1:0] ptrLoc,
  output logic [ADDR_W-1:0] wbData,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              addrValid,
  output logic              midFlag,
  output logic              wrapFlag
);

  localparam int IDX_W = 2 + SA_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] BLK_TOGGLE = ONE << BLK_W;

  // ---- message context decode ----
  logic              isRecv, useRing;
  logic [1:0]        tblDir;
  scheme_e           schemeD;
  logic [3:0]        log2D;
  logic [ADDR_W-1:0] locD, tblBase;

  always_comb begin
    isRecv  = (dirIn != DIR_TX);
    useRing = isRecv && ctrlGlobal;
    if (dirIn == DIR_TX)                    tblDir = DIR_TX;
    else if (dirIn == DIR_RX || !sepBcast)  tblDir = DIR_RX;
    else                                    tblDir = DIR_BC;

    if (useRing || ctrlMm != 3'd0) schemeD = SCH_RING;
    else if (isRecv)               schemeD = SCH_DOUBLE;
    else                           schemeD = SCH_SINGLE;

    log2D   = useRing ? ringLog2(globalSize) : ringLog2(ctrlMm);
    tblBase = areaSel ? TBL_B_BASE : TBL_A_BASE;
    if (useRing) locD = areaSel ? RING_B_LOC : RING_A_LOC;
    else         locD = tblBase + ADDR_W'({tblDir, subAddr});
  end

  logic [3:0] log2Q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scheme <= SCH_SINGLE;
      log2Q  <= 4'd7;
      ptrLoc <= '0;
    end else if (stb.latchCtx) begin
      scheme <= schemeD;
      log2Q  <= log2D;
      ptrLoc <= locD;
    end
  end

  // ---- pointer and word addressing ----
  logic [ADDR_W-1:0] ptrQ, ringMask, ringHalf, ringNext, addrD;
  logic [BLK_W-1:0]  idxQ;

  always_comb begin
    ringMask = (ONE << log2Q) - ONE;
    ringHalf = ONE << (log2Q - 4'd1);
    ringNext = (ptrQ & ~ringMask) | ((ptrQ + ONE) & ringMask);
    unique case (scheme)
      SCH_SINGLE: addrD = {ptrQ[ADDR_W-1:BLK_W], idxQ};
      SCH_DOUBLE: addrD = {ptrQ[ADDR_W-1:BLK_W+1], ~ptrQ[BLK_W], idxQ};
      default:    addrD = ptrQ;
    endcase
    wbData = (scheme == SCH_RING) ? ptrQ : (ptrQ ^ BLK_TOGGLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptrQ      <= '0;
      idxQ      <= '0;
      wordAddr  <= '0;
      addrValid <= 1'b0;
      midFlag   <= 1'b0;
      wrapFlag  <= 1'b0;
    end else begin
      addrValid <= stb.advance;
      midFlag   <= 1'b0;
      wrapFlag  <= 1'b0;
      if (stb.loadPtr) begin
        ptrQ <= memRdata;
        idxQ <= '0;
      end else if (stb.advance) begin
        wordAddr <= addrD;
        idxQ     <= idxQ + 1'b1;
        if (scheme == SCH_RING) begin
          ptrQ     <= ringNext;
          midFlag  <= (ringNext & ringMask) == ringHalf;
          wrapFlag <= (ringNext & ringMask) == '0;
        end
      end
    end
  end

  // IDX_W documents the table offset width {dir, subaddress}
  initial begin
    if (IDX_W > ADDR_W) $error("table offset wider than address");
  end

endmodule

// File: rtl/dword_bufmgr.sv
module dword_bufmgr
  import bufmgr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SA_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msgStart,
  input  logic [1:0]        dirIn,
  input  logic [SA_W-1:0]   subAddr,
  input  logic [2:0]        ctrlMm,
  input  logic              ctrlGlobal,
  input  logic              areaSel,
  input  logic              sepBcast,
  input  logic [2:0]        globalSize,
  input  logic              wordReq,
  input  logic              msgEnd,
  input  logic              msgOk,
  output logic              busy,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              addrValid,
  output logic              midFlag,
  output logic              wrapFlag,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [ADDR_W-1:0] memWdata,
  input  logic [ADDR_W-1:0] memRdata
);

  strobe_t stb;
  scheme_e scheme;

  bufmgr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .msgStart(msgStart), .wordReq(wordReq),
    .msgEnd(msgEnd), .msgOk(msgOk), .scheme(scheme), .stb(stb),
    .memRe(memRe), .memWe(memWe), .busy(busy)
  );

  bufmgr_dpath #(.ADDR_W(ADDR_W), .SA_W(SA_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .dirIn(dirIn), .subAddr(subAddr),
    .ctrlMm(ctrlMm), .ctrlGlobal(ctrlGlobal), .areaSel(areaSel),
    .sepBcast(sepBcast), .globalSize(globalSize), .memRdata(memRdata),
    .scheme(scheme), .ptrLoc(memAddr), .wbData(memWdata),
    .wordAddr(wordAddr), .addrValid(addrValid), .midFlag(midFlag),
    .wrapFlag(wrapFlag)
  );

endmodule

// File: rtl/bufmgr_chk.sv
module bufmgr_chk (
  input logic clk,
  input logic rst_n,
  input logic msgStart,
  input logic wordReq,
  input logic msgEnd,
  input logic msgOk,
  input logic busy,
  input logic addrValid,
  input logic midFlag,
  input logic wrapFlag,
  input logic memRe,
  input logic memWe
);

  // R10
  addr_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addrValid |-> ($past(wordReq) && $past(busy)));

  // R9
  wb_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> ($past(msgEnd) && $past(msgOk)));

  // R2
  fetch_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memRe |-> ($past(msgStart) && !$past(busy)));

  // R8
  flag_with_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (midFlag || wrapFlag) |-> addrValid);

  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(midFlag && wrapFlag));

  // R1
  mem_port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(memRe && memWe));

  // R2
  start_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msgStart && !busy) |=> busy);

endmodule

bind dword_bufmgr bufmgr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .msgStart(msgStart), .wordReq(wordReq),
  .msgEnd(msgEnd), .msgOk(msgOk), .busy(busy), .addrValid(addrValid),
  .midFlag(midFlag), .wrapFlag(wrapFlag), .memRe(memRe), .memWe(memWe)
);

// File: tb/dword_bufmgr_test.sv
`timescale 1ns/1ps
module dword_bufmgr_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msgStart = 0, ctrlGlobal = 0, areaSel = 0, sepBcast = 0;
  logic        wordReq = 0, msgEnd = 0, msgOk = 0;
  logic [1:0]  dirIn = 0;
  logic [4:0]  subAddr = 0;
  logic [2:0]  ctrlMm = 0, globalSize = 0;
  logic        busy, addrValid, midFlag, wrapFlag, memRe, memWe;
  logic [15:0] wordAddr, memAddr, memWdata;
  logic [15:0] memRdata = 16'h0;

  always #10 clk = ~clk;

  dword_bufmgr uut (
    .clk(clk), .rst_n(rst_n), .msgStart(msgStart), .dirIn(dirIn),
    .subAddr(subAddr), .ctrlMm(ctrlMm), .ctrlGlobal(ctrlGlobal),
    .areaSel(areaSel), .sepBcast(sepBcast), .globalSize(globalSize),
    .wordReq(wordReq), .msgEnd(msgEnd), .msgOk(msgOk), .busy(busy),
    .wordAddr(wordAddr), .addrValid(addrValid), .midFlag(midFlag),
    .wrapFlag(wrapFlag), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // synchronous RAM model for the pointer words
  logic [15:0] ram [int];
  always @(posedge clk) begin
    if (memWe) ram[int'(memAddr)] = memWdata;
    if (memRe) memRdata <= ram.exists(int'(memAddr)) ? ram[int'(memAddr)] : 16'h0;
  end

  int nChecks = 0, nFails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct packed { logic [15:0] a; logic m; logic w; } exp_t;
  exp_t expQ[$];
  string curReq = "R6";

  always @(negedge clk) begin
    if (rst_n && addrValid) begin
      if (expQ.size() == 0) begin
        check(0, "R10", "unexpected address", {16'h0, wordAddr}, 32'h0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(wordAddr == e.a, curReq, "word address", {16'h0, wordAddr}, {16'h0, e.a});
        check(midFlag == e.m && wrapFlag == e.w, "R8", "mid/wrap flags",
              {30'h0, midFlag, wrapFlag}, {30'h0, e.m, e.w});
      end
    end
  end

  // d: 0 rx, 1 tx, 2 bcast
  task automatic runMsg(input logic [1:0] d, input logic [4:0] sa, input logic [2:0] mm,
                        input bit g, input bit ar, input bit sep, input logic [2:0] gs,
                        input int n, input bit ok, input string req);
    bit          recv, ring, dbl;
    logic [1:0]  td;
    logic [15:0] loc, ptr, p, mask, nxt, wb;
    int          lg;
    recv = (d != 2'd1);
    ring = (recv && g) || (mm != 3'd0);
    dbl  = !ring && recv;
    td   = (d == 2'd1) ? 2'd1 : ((d == 2'd0 || !sep) ? 2'd0 : 2'd2);
    if (recv && g) begin
      loc = ar ? 16'h0105 : 16'h0101;
      lg  = (gs == 0) ? 7 : 6 + int'(gs);
    end else begin
      loc = (ar ? 16'h01C0 : 16'h0140) + 16'(td) * 16'd32 + 16'(sa);
      lg  = (mm == 0) ? 7 : 6 + int'(mm);
    end
    ptr  = ram.exists(int'(loc)) ? ram[int'(loc)] : 16'h0;
    mask = 16'((32'd1 << lg) - 1);
    p = ptr;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      if (ring) begin
        nxt = (p & ~mask) | ((p + 16'd1) & mask);
        e.a = p; e.m = ((nxt & mask) == 16'((32'd1 << lg) >> 1)); e.w = ((nxt & mask) == 0);
        p = nxt;
      end else begin
        e.a = dbl ? {ptr[15:6], ~ptr[5], 5'(k)} : {ptr[15:5], 5'(k)};
        e.m = 0; e.w = 0;
      end
      expQ.push_back(e);
    end
    wb = ring ? p : (ptr ^ 16'h0020);
    curReq = req;

    @(negedge clk);
    dirIn = d; subAddr = sa; ctrlMm = mm; ctrlGlobal = g; areaSel = ar;
    sepBcast = sep; globalSize = gs; msgStart = 1;
    @(negedge clk);
    msgStart = 0;
    check(memRe && memAddr == loc, req, "pointer fetch location",
          {15'h0, memRe, memAddr}, {16'h1, loc});
    @(negedge clk);
    @(negedge clk);
    wordReq = 1;
    repeat (n) @(negedge clk);
    wordReq = 0;
    msgEnd = 1; msgOk = ok;
    @(negedge clk);
    msgEnd = 0; msgOk = 0;
    if (ok && (ring || dbl))
      check(memWe && memAddr == loc && memWdata == wb, "R9", "pointer write-back",
            {memWe, 15'h0, memWdata}, {1'b1, 15'h0, wb});
    else
      check(!memWe && !busy, "R9", "no write-back", {30'h0, memWe, busy}, 32'h0);
    @(negedge clk);
    check(expQ.size() == 0, "R10", "words outstanding", expQ.size(), 0);
    check(ram[int'(loc)] == ((ok && (ring || dbl)) ? wb : ptr), "R9", "stored pointer",
          {16'h0, ram[int'(loc)]}, {16'h0, (ok && (ring || dbl)) ? wb : ptr});
  endtask

  initial begin
    ram[32'h0163] = 16'h0400;  // tx sa3 area A
    ram[32'h0145] = 16'h0800;  // rx sa5 area A
    ram[32'h01E7] = 16'h107C;  // tx sa7 area B
    ram[32'h01C9] = 16'h207E;  // rx sa9 area B
    ram[32'h0184] = 16'h0A00;  // bcast sa4 area A (separate)
    ram[32'h0144] = 16'h0C40;  // rx sa4 area A
    ram[32'h0105] = 16'h31FE;  // shared ring area B
    ram[32'h0101] = 16'h6010;  // shared ring area A
    ram[32'h014B] = 16'h4FFE;  // rx sa11 area A, 8192 ring

    repeat (4) @(negedge clk);
    // R1: reset state
    check(!busy && !addrValid && !midFlag && !wrapFlag && !memRe && !memWe, "R1",
          "reset outputs", {26'h0, busy, addrValid, midFlag, wrapFlag, memRe, memWe}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    // R10: request while idle is ignored
    wordReq = 1;
    @(negedge clk);
    wordReq = 0;
    @(negedge clk);
    check(!addrValid && !busy, "R10", "idle request ignored", {30'h0, addrValid, busy}, 32'h0);

    runMsg(2'd1, 5'd3, 3'd0, 0, 0, 0, 3'd0, 4, 1, "R4");   // tx single
    runMsg(2'd1, 5'd3, 3'd0, 1, 0, 0, 3'd0, 3, 1, "R4");   // tx, global bit ignored
    runMsg(2'd0, 5'd5, 3'd0, 0, 0, 0, 3'd0, 3, 1, "R5");   // double, toggles
    runMsg(2'd0, 5'd5, 3'd0, 0, 0, 0, 3'd0, 2, 1, "R5");   // toggles back
    runMsg(2'd0, 5'd5, 3'd0, 0, 0, 0, 3'd0, 2, 0, "R5");   // failed: no toggle
    runMsg(2'd1, 5'd7, 3'd1, 0, 1, 0, 3'd0, 6, 1, "R6");   // 128 ring wraps, area B R11
    runMsg(2'd0, 5'd9, 3'd2, 0, 1, 0, 3'd0, 3, 0, "R6");   // 256 ring midpoint, failed
    runMsg(2'd0, 5'd9, 3'd2, 0, 1, 0, 3'd0, 3, 1, "R6");   // same ring, pointer restored
    runMsg(2'd2, 5'd4, 3'd0, 0, 0, 1, 3'd0, 2, 1, "R3");   // bcast separated
    runMsg(2'd2, 5'd4, 3'd0, 0, 0, 0, 3'd0, 2, 1, "R3");   // bcast shares rx entry
    runMsg(2'd0, 5'd2, 3'd0, 1, 1, 0, 3'd3, 4, 1, "R7");   // shared ring B, 512
    runMsg(2'd2, 5'd8, 3'd5, 1, 0, 0, 3'd0, 3, 1, "R11");  // shared ring A, default 128
    runMsg(2'd0, 5'd11, 3'd7, 0, 0, 0, 3'd0, 3, 1, "R6");  // 8192 ring midpoint

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule